// File: doc/BRIEF.md
# Paced Block-to-Byte Serializer

This block takes a 128-bit result block (four 32-bit words packed side by side on one input, the first word in the top bits) and sends it out as sixteen 8-bit bytes on a narrow output. A single load strobe captures the block. The bytes then go out at a programmable rate: one byte every 2^n clocks, where n is a 4-bit exponent supplied by the configuration logic. The first byte of a block appears on the cycle right after the load. After that, a byte-valid pulse marks every new byte.

A busy flag covers the whole transfer. While it is high, the block accepts no new block, and the exponent it captured stays in force. Users of the block should hand it blocks no faster than it can drain them. A source that waits for busy to drop can send blocks back to back with no gap. An exponent of zero means "not configured" and selects the default rate of one byte per 16 clocks.

Top module: `pace_serializer`

## Requirements
- R1: A block sends exactly sixteen bytes, highest byte first: bits [127:120], then [119:112], and so on down to [7:0].
- R2: When load_i is high at a clock edge and busy_o is low, the edge accepts the block. The first byte is on byte_o, with byte_vld_o high, in the very next cycle.
- R3: For an exponent n from 1 to 15, consecutive byte_vld_o pulses within a block are exactly 2^n clocks apart.
- R4: An exponent of 0 selects a spacing of 16 clocks, the same as exponent 4.
- R5: byte_vld_o is high for one cycle per byte and is never high while busy_o is low.
- R6: busy_o goes high in the cycle after an accepted load. It stays high through the cycle in which the sixteenth byte is valid, and it is low in the cycle after that.
- R7: A load_i that arrives while busy_o is high is ignored. This includes the cycle of the sixteenth byte. The block in flight then continues unchanged, and no extra byte is produced.
- R8: The exponent is sampled only at an accepted load. Changing rate_exp_i during a block has no effect on that block's spacing.
- R9: After reset, byte_o is 0, byte_vld_o is 0 and busy_o is 0.
- R10: Between pulses of byte_vld_o, byte_o holds the last byte that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_i | input | 128 | Result block; the first word sits in the top 32 bits |
| load_i | input | 1 | Load strobe; accepted only when not busy |
| rate_exp_i | input | 4 | Rate exponent n (spacing 2^n clocks); 0 selects 16 clocks |
| byte_o | output | 8 | Current output byte |
| byte_vld_o | output | 1 | One-cycle pulse marking a new byte |
| busy_o | output | 1 | High while a block is being sent |

## Verification
The bench checks every byte against a queue of expected values and expected cycle numbers. This means that a design that emits the bytes in the wrong order is caught. So is one that drops or adds a byte, or one whose first byte comes a cycle late. It also catches a design whose spacing is off by one clock, for example one that compares the counter against 2^n instead of 2^n-1.

Several stimuli target the load and rate rules. One load arrives in the middle of a block, together with a new exponent. A design that restarts the block, or that re-samples the rate, would produce extra bytes or the wrong spacing. Another load lands in the exact cycle of the sixteenth byte. A design that drops busy one cycle early would start a new block there. Exponent 0 is exercised to catch a design that takes it literally and sends a byte every clock. Busy is sampled on both sides of its falling edge.

// File: rtl/pace_pkg.sv
package pace_pkg;
  localparam int EXP_W   = 4;
  localparam int CNT_W   = (1 << EXP_W) - 1;
  localparam int DEF_EXP = 4;

  // exponent 0 means unconfigured: fall back to the default rate
  function automatic logic [EXP_W-1:0] eff_exp(input logic [EXP_W-1:0] e);
    return (e == '0) ? EXP_W'(DEF_EXP) : e;
  endfunction

  // terminal count of the byte pacing counter: 2^n - 1
  function automatic logic [CNT_W-1:0] period_last(input logic [EXP_W-1:0] e);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (one << eff_exp(e)) - one;
  endfunction
endpackage

// File: rtl/pace_tick.sv
module pace_tick #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_lim_w;

  assign at_lim_w = (cnt_q == lim_i);
  assign tick_o   = run_i && at_lim_w && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i) |-> (cnt_q <= lim_i)); // R3
endmodule

// File: rtl/pace_shifter.sv
module pace_shifter #(
  parameter int BYTES  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_i,
  input  logic                            shift_i,
  input  logic [(BYTES-1)*BYTE_W-1:0]     rest_i,
  output logic [BYTE_W-1:0]               head_o
);
  localparam int LANES = BYTES - 1;

  logic [LANES-1:0][BYTE_W-1:0] lane_q;
  logic [LANES-1:0][BYTE_W-1:0] src_w;
  logic [LANES-1:0][BYTE_W-1:0] up_w;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign src_w[i] = rest_i[LANES*BYTE_W-1 - i*BYTE_W -: BYTE_W];
    if (i == LANES-1) begin : g_tail
      assign up_w[i] = '0;
    end else begin : g_body
      assign up_w[i] = lane_q[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lane_q <= '0;
    else if (load_i)   lane_q <= src_w;
    else if (shift_i)  lane_q <= up_w;
  end

  assign head_o = lane_q[0];

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i)); // R7
endmodule

// File: rtl/pace_serializer.sv
module pace_serializer
  import pace_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WORD_W*WORDS-1:0]   blk_i,
  input  logic                      load_i,
  input  logic [EXP_W-1:0]          rate_exp_i,
  output logic [BYTE_W-1:0]         byte_o,
  output logic                      byte_vld_o,
  output logic                      busy_o
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int BYTES = BLK_W / BYTE_W;
  localparam int REM_W = $clog2(BYTES);
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(BYTES - 1);

  logic              busy_q, vld_q;
  logic [BYTE_W-1:0] byte_q;
  logic [REM_W-1:0]  rem_q;
  logic [CNT_W-1:0]  lim_q;

  // named internal events
  logic              accept_w;
  logic              run_w;
  logic              byte_tick_w;
  logic              last_byte_w;
  logic [BYTE_W-1:0] head_w;

  assign accept_w    = load_i && !busy_q;
  assign run_w       = busy_q && (rem_q != '0);
  assign last_byte_w = vld_q && (rem_q == '0);

  pace_tick #(.CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept_w),
    .run_i  (run_w),
    .lim_i  (lim_q),
    .tick_o (byte_tick_w)
  );

  pace_shifter #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .shift_i (byte_tick_w),
    .rest_i  (blk_i[BLK_W-BYTE_W-1:0]),
    .head_o  (head_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      byte_q <= '0;
      rem_q  <= '0;
      lim_q  <= period_last('0);
    end else if (accept_w) begin
      busy_q <= 1'b1;
      vld_q  <= 1'b1;
      byte_q <= blk_i[BLK_W-1 -: BYTE_W];
      rem_q  <= REM_FULL;
      lim_q  <= period_last(rate_exp_i);
    end else begin
      vld_q <= byte_tick_w;
      if (byte_tick_w) begin
        byte_q <= head_w;
        rem_q  <= rem_q - REM_W'(1);
      end
      if (last_byte_w) busy_q <= 1'b0;
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign busy_o     = busy_q;

  AST_VLD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> busy_q); // R5
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R5
  AST_BUSY_RISE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (vld_q && rem_q == REM_FULL)); // R2
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(vld_q) && $past(rem_q) == '0)); // R6
  AST_IGNORED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load_i) |=> !(vld_q && rem_q == REM_FULL)); // R7
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(lim_q)); // R8
endmodule

// File: tb/pace_serializer_bench.sv
module pace_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] blk = '0;
  logic         load = 1'b0;
  logic [3:0]   rate = '0;
  logic [7:0]   byte_o;
  logic         byte_vld;
  logic         busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] last_b = '0;
  logic [7:0] exp_byte_q[$];
  int         exp_cyc_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pace_serializer u_pace_serializer (
    .clk(clk), .rst_n(rst_n), .blk_i(blk), .load_i(load),
    .rate_exp_i(rate), .byte_o(byte_o), .byte_vld_o(byte_vld), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int spacing(input logic [3:0] e);
    return (e == 4'd0) ? 16 : (1 << e);
  endfunction

  // driver: called at a negedge; pushes the expected bytes and their cycles
  task automatic send(input logic [127:0] b, input logic [3:0] e, output int first, output int p);
    p = spacing(e);
    first = cyc + 1;
    for (int k = 0; k < 16; k++) begin
      exp_byte_q.push_back(b[127-8*k -: 8]);   // R1 highest byte first
      exp_cyc_q.push_back(first + k*p);         // R2, R3
    end
    blk = b; rate = e; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // check busy on both sides of the last byte; optionally poke a load at the last byte
  task automatic finish(input int first, input int p, input bit poke);
    wait_to(first + 15*p);
    check(busy === 1'b1, "R6", "busy in last-byte cycle", busy, 1);
    if (poke) begin
      blk = {16{8'hEE}}; load = 1'b1;                 // R7 ignored at last byte
    end
    @(negedge clk);
    load = 1'b0;
    check(busy === 1'b0, "R6", "busy after last byte", busy, 0);
    check(byte_vld === 1'b0, "R7", "no byte after last byte", byte_vld, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin
        if (exp_byte_q.size() == 0) begin
          check(1'b0, "R7", "unexpected byte", byte_o, -1);
        end else begin
          logic [7:0] eb;
          int ec;
          eb = exp_byte_q.pop_front();
          ec = exp_cyc_q.pop_front();
          check(byte_o === eb, "R1", "byte value", byte_o, eb);
          check(cyc == ec, "R3", "byte cycle", cyc, ec);
        end
        check(busy === 1'b1, "R5", "valid only while busy", busy, 1);
        last_b = byte_o;
      end else if (busy) begin
        if (byte_o !== last_b) check(1'b0, "R10", "byte held", byte_o, last_b);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", cyc, WATCHDOG);
    report();
    $finish;
  end

  initial begin
    int f, p;
    repeat (3) @(negedge clk);
    check(byte_o === 8'h00, "R9", "reset byte", byte_o, 0);
    check(byte_vld === 1'b0, "R9", "reset valid", byte_vld, 0);
    check(busy === 1'b0, "R9", "reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fastest rate, exponent 1
    send(128'h00112233_44556677_8899AABB_CCDDEEFF, 4'd1, f, p);
    check(byte_vld === 1'b1, "R2", "first byte next cycle", byte_vld, 1);
    finish(f, p, 1'b0);

    // exponent 2 with a load and a rate change mid-block (R7, R8)
    send(128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 4'd2, f, p);
    wait_to(f + 5);
    blk = {16{8'h55}}; rate = 4'd1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    finish(f, p, 1'b0);

    // exponent 0 falls back to 16 clocks (R4)
    send(128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D, 4'd0, f, p);
    finish(f, p, 1'b0);

    // exponent 3 with a load in the last-byte cycle, then an immediate new block
    send(128'h13579BDF_2468ACE0_0F1E2D3C_4B5A6978, 4'd3, f, p);
    finish(f, p, 1'b1);
    send(128'hA5A5A5A5_5A5A5A5A_FFFF0000_0000FFFF, 4'd5, f, p);
    finish(f, p, 1'b0);

    repeat (4) @(negedge clk);
    check(exp_byte_q.size() == 0, "R1", "all bytes delivered", exp_byte_q.size(), 0);
    report();
    $finish;
  end
endmodule